// File: doc/BRIEF.md
# LCD Panel Timing and Pixel Controller

This block drives a small passive or TFT LCD panel. It sequences each frame as active lines followed by blank wait lines. It produces a horizontal sync, a vertical sync, a first-line marker and a data-enable strobe, and it turns a stream of pixel codes into panel data. Pixel codes arrive on a ready/valid stream. A code is taken on every clock edge at which `pix_ready` is high, so the frame never stalls for lack of data. A missing pixel repeats the previous one and sets a sticky flag.

Colour modes look up each 4- or 8-bit code in a 256-entry table of 12-bit RGB values. The result is sent either as 12 bits or as a narrow 9-bit bus. Grayscale modes of 1, 2 or 4 bits per pixel drive a single dot per pixel. Intermediate gray levels come from frame-rate-control modulation: a two-bit frame counter is combined with the pixel's column and row. In grayscale dual-scan mode the upper and lower halves of the panel are refreshed together from one stream word, so each frame takes half as many line times.

All settings and the colour table are written through a simple write-only register port. An end-of-frame interrupt pulses once per frame.

Top module: `lcd_panel_ctrl`

## Requirements
- R1: After reset, `lcd_hsync`, `lcd_vsync`, `lcd_first`, `lcd_de`, `lcd_data`, `frame_irq`, `underrun` and `pix_ready` are all 0, and the controller is idle.
- R2: While enabled, each line has `h_active` clocks in the ACTIVE state. `pix_ready` is high during these clocks, and each one produces one clock of `lcd_de` (active level) exactly one clock later, with the pixel taken at that edge.
- R3: After every active line, the line-wait state lasts `line_wait` clocks. `lcd_hsync` is at its active level for exactly those clocks, and `lcd_de` is never active at the same time.
- R4: After the last active line there are `frame_wait` blank lines, each `h_active + line_wait` clocks long. `lcd_vsync` is active during the first of them and `lcd_first` during the first active line and its line wait. The frame period is therefore (rows + `frame_wait`) × (`h_active` + `line_wait`) clocks, where rows is `v_active`, or `v_active/2` in dual-scan.
- R5: Control bits 6, 7, 8 and 9 invert `lcd_hsync`, `lcd_vsync`, `lcd_first` and `lcd_de` respectively when set.
- R6: `frame_irq` is a one-clock pulse, once per frame, in the first frame-wait clock.
- R7: In 8-bit colour mode (mode code 4), `lcd_data` equals the colour-table entry indexed by `pix_data[7:0]`.
- R8: In 4-bit colour mode (mode code 3), only `pix_data[3:0]` indexes the table.
- R9: With control bit 5 set, colour output is 9 bits wide: `lcd_data` = {3'b0, R[3:1], G[3:1], B[3:1]}, where an entry is {R, G, B} with R in bits 11:8.
- R10: In grayscale modes the dot is `lcd_data[0]`. It is lit when duty > (frame + column + row) mod 4. Duty is 4·bit0 for mode 0 (1 bpp). For mode 1 (2 bpp) it is the 2-bit level, except that level 3 gives 4. For mode 2 (4 bpp) it is (level+2)/4. So a pixel is lit in exactly duty of any 4 consecutive frames.
- R11: Control bit 4 selects dual-scan, which has effect in grayscale modes only. The frame has `v_active/2` rows. `lcd_data[0]` carries the upper-half dot from `pix_data[3:0]`, and `lcd_data[4]` carries the lower-half dot from `pix_data[11:8]`, using row + `v_active/2` as its row.
- R12: If `pix_valid` is low while `pix_ready` is high, the previous pixel is held on `lcd_data` and `underrun` is set one clock later. The flag stays set until the control register is written.
- R13: In the register port, an address with bit 8 set writes colour entry `reg_addr[7:0]`. Otherwise the address selects 0 `h_active`, 1 `v_active`, 2 `line_wait`, 3 `frame_wait` or 4 control. Control bit 0 enables the controller and bits 3:1 select the mode. A write takes effect at the edge where `reg_we` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register or colour-table address |
| reg_wdata | input | 12 | Write data |
| pix_valid | input | 1 | Pixel word valid |
| pix_ready | output | 1 | Pixel word taken at this edge |
| pix_data | input | 12 | Upper code [7:0], lower gray code [11:8] |
| lcd_hsync | output | 1 | Line sync, polarity programmable |
| lcd_vsync | output | 1 | Frame sync, polarity programmable |
| lcd_first | output | 1 | First-line marker, polarity programmable |
| lcd_de | output | 1 | Data enable, polarity programmable |
| lcd_data | output | 12 | Panel pixel data |
| frame_irq | output | 1 | End-of-frame pulse |
| underrun | output | 1 | Sticky missing-pixel flag |

## Verification
Every panel output is registered from the sequencer state, so each output is due exactly one clock after the edge that decides it. A pixel taken at an edge where `pix_ready` is high appears on `lcd_data`, together with `lcd_de`, after that same edge. The bench samples on falling edges. Whenever it sees `pix_ready` high, it records the code it presents, and it compares the next data-enabled sample against that record. Sync widths and frame periods are counted in windows that start at a `frame_irq` pulse, so the expected counts do not depend on when the controller was enabled. The underrun flag and its clearing are checked at the first falling edge after the edge that causes each.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_LWAIT,
        ST_FWAIT
    } lcd_state_t;

    typedef enum logic [2:0] {
        PM_GRAY1  = 3'd0,
        PM_GRAY2  = 3'd1,
        PM_GRAY4  = 3'd2,
        PM_COLOR4 = 3'd3,
        PM_COLOR8 = 3'd4
    } pix_mode_t;

    localparam int GRAY_W   = 4;
    localparam int CTRL_W   = 10;
    localparam int REG_HACT = 0;
    localparam int REG_VACT = 1;
    localparam int REG_LWT  = 2;
    localparam int REG_FWT  = 3;
    localparam int REG_CTRL = 4;
    localparam int POL_HS   = 0;
    localparam int POL_VS   = 1;
    localparam int POL_FL   = 2;
    localparam int POL_DE   = 3;
endpackage

// File: rtl/lcd_regs.sv
module lcd_regs import lcd_pkg::*; #(
    parameter int CNT_W   = 12,
    parameter int IDX_W   = 8,
    parameter int COLOR_W = 12,
    localparam int DEPTH  = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W:0]     addr,
    input  logic [CNT_W-1:0]   wdata,
    input  logic [IDX_W-1:0]   pal_idx,
    output logic [CNT_W-1:0]   h_act,
    output logic [CNT_W-1:0]   v_act,
    output logic [CNT_W-1:0]   l_wait,
    output logic [CNT_W-1:0]   f_wait,
    output logic               en,
    output pix_mode_t          mode,
    output logic               dual,
    output logic               narrow,
    output logic [3:0]         pol,
    output logic               ctrl_wr,
    output logic [COLOR_W-1:0] pal_rgb
);
    logic [CTRL_W-1:0]  ctrl_q;
    logic [COLOR_W-1:0] pal_mem [DEPTH];
    logic               tbl_sel;

    assign tbl_sel = addr[IDX_W];
    assign ctrl_wr = we && !tbl_sel && (addr[IDX_W-1:0] == IDX_W'(REG_CTRL));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_act  <= CNT_W'(1);
            v_act  <= CNT_W'(2);
            l_wait <= CNT_W'(1);
            f_wait <= CNT_W'(1);
            ctrl_q <= '0;
        end else if (we && !tbl_sel) begin
            unique case (addr[IDX_W-1:0])
                IDX_W'(REG_HACT): h_act  <= wdata;
                IDX_W'(REG_VACT): v_act  <= wdata;
                IDX_W'(REG_LWT):  l_wait <= wdata;
                IDX_W'(REG_FWT):  f_wait <= wdata;
                IDX_W'(REG_CTRL): ctrl_q <= wdata[CTRL_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (we && tbl_sel) pal_mem[addr[IDX_W-1:0]] <= wdata[COLOR_W-1:0];
    end

    assign pal_rgb = pal_mem[pal_idx];
    assign en      = ctrl_q[0];
    assign mode    = pix_mode_t'(ctrl_q[3:1]);
    assign dual    = ctrl_q[4];
    assign narrow  = ctrl_q[5];
    assign pol     = ctrl_q[9:6];
endmodule

// File: rtl/lcd_timing.sv
module lcd_timing import lcd_pkg::*; #(
    parameter int CNT_W  = 12,
    localparam int LINE_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] h_act,
    input  logic [CNT_W-1:0] v_act,
    input  logic [CNT_W-1:0] l_wait,
    input  logic [CNT_W-1:0] f_wait,
    input  logic             dual,
    output lcd_state_t       st,
    output logic [1:0]       col_l,
    output logic [1:0]       row_l,
    output logic [1:0]       rowlo_l,
    output logic             row_zero,
    output logic [1:0]       fc,
    output logic             eof_set
);
    lcd_state_t        st_n;
    logic [LINE_W-1:0] col, col_n;
    logic [CNT_W-1:0]  row, row_n;
    logic [1:0]        fc_n;
    logic [CNT_W-1:0]  rows, half;
    logic [LINE_W-1:0] h_last, lw_last, bl_last;

    assign half    = v_act >> 1;
    assign rows    = dual ? half : v_act;
    assign h_last  = LINE_W'(h_act) - 1'b1;
    assign lw_last = LINE_W'(l_wait) - 1'b1;
    assign bl_last = LINE_W'(h_act) + LINE_W'(l_wait) - 1'b1;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            col <= '0;
            row <= '0;
            fc  <= '0;
        end else begin
            st  <= st_n;
            col <= col_n;
            row <= row_n;
            fc  <= fc_n;
        end
    end

    // transitions
    always_comb begin
        st_n  = st;
        col_n = col;
        row_n = row;
        fc_n  = fc;
        if (!en) begin
            st_n  = ST_IDLE;
            col_n = '0;
            row_n = '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    st_n  = ST_ACTIVE;
                    col_n = '0;
                    row_n = '0;
                end
                ST_ACTIVE: begin
                    if (col == h_last) begin
                        st_n  = ST_LWAIT;
                        col_n = '0;
                    end else col_n = col + 1'b1;
                end
                ST_LWAIT: begin
                    if (col == lw_last) begin
                        col_n = '0;
                        if (row == rows - 1'b1) begin
                            st_n  = ST_FWAIT;
                            row_n = '0;
                        end else begin
                            st_n  = ST_ACTIVE;
                            row_n = row + 1'b1;
                        end
                    end else col_n = col + 1'b1;
                end
                ST_FWAIT: begin
                    if (col == bl_last) begin
                        col_n = '0;
                        if (row == f_wait - 1'b1) begin
                            st_n  = ST_ACTIVE;
                            row_n = '0;
                            fc_n  = fc + 1'b1;
                        end else row_n = row + 1'b1;
                    end else col_n = col + 1'b1;
                end
            endcase
        end
    end

    assign eof_set  = en && (st == ST_LWAIT) && (col == lw_last) && (row == rows - 1'b1);
    assign col_l    = col[1:0];
    assign row_l    = row[1:0];
    assign rowlo_l  = row[1:0] + half[1:0];
    assign row_zero = (row == '0);
endmodule

// File: rtl/lcd_pixfmt.sv
module lcd_pixfmt import lcd_pkg::*; #(
    parameter int IDX_W   = 8,
    parameter int COLOR_W = 12,
    localparam int CH_W   = COLOR_W / 3
) (
    input  pix_mode_t          mode,
    input  logic               narrow,
    input  logic               dual,
    input  logic [1:0]         fc,
    input  logic [1:0]         col_l,
    input  logic [1:0]         row_l,
    input  logic [1:0]         rowlo_l,
    input  logic [IDX_W-1:0]   code_up,
    input  logic [GRAY_W-1:0]  code_lo,
    input  logic [COLOR_W-1:0] pal_rgb,
    output logic [IDX_W-1:0]   pal_idx,
    output logic [COLOR_W-1:0] pix_out
);
    function automatic logic [2:0] gray_duty(pix_mode_t m, logic [GRAY_W-1:0] c);
        case (m)
            PM_GRAY1: return c[0] ? 3'd4 : 3'd0;
            PM_GRAY2: return (c[1:0] == 2'd3) ? 3'd4 : {1'b0, c[1:0]};
            default:  return 3'((5'(c) + 5'd2) >> 2);
        endcase
    endfunction

    logic       is_color, dot_up, dot_lo;
    logic [1:0] ph_up, ph_lo;

    assign is_color = (mode == PM_COLOR4) || (mode == PM_COLOR8);
    assign pal_idx  = (mode == PM_COLOR4) ? IDX_W'(code_up[GRAY_W-1:0]) : code_up;
    assign ph_up    = fc + col_l + row_l;
    assign ph_lo    = fc + col_l + rowlo_l;
    assign dot_up   = gray_duty(mode, code_up[GRAY_W-1:0]) > {1'b0, ph_up};
    assign dot_lo   = gray_duty(mode, code_lo) > {1'b0, ph_lo};

    always_comb begin
        pix_out = '0;
        if (is_color) begin
            if (narrow)
                pix_out = {3'b000,
                           pal_rgb[3*CH_W-1 -: CH_W-1],
                           pal_rgb[2*CH_W-1 -: CH_W-1],
                           pal_rgb[CH_W-1 -: CH_W-1]};
            else
                pix_out = pal_rgb;
        end else begin
            pix_out[0] = dot_up;
            pix_out[4] = dot_lo & dual;
        end
    end
endmodule

// File: rtl/lcd_panel_ctrl.sv
module lcd_panel_ctrl import lcd_pkg::*; #(
    parameter int CNT_W     = 12,
    parameter int PAL_DEPTH = 256,
    parameter int COLOR_W   = 12,
    localparam int IDX_W    = $clog2(PAL_DEPTH),
    localparam int ADDR_W   = IDX_W + 1,
    localparam int PIX_W    = IDX_W + GRAY_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [CNT_W-1:0]   reg_wdata,
    input  logic               pix_valid,
    output logic               pix_ready,
    input  logic [PIX_W-1:0]   pix_data,
    output logic               lcd_hsync,
    output logic               lcd_vsync,
    output logic               lcd_first,
    output logic               lcd_de,
    output logic [COLOR_W-1:0] lcd_data,
    output logic               frame_irq,
    output logic               underrun
);
    logic [CNT_W-1:0]   h_act, v_act, l_wait, f_wait;
    logic               en, dual, narrow, ctrl_wr, dual_eff;
    pix_mode_t          mode;
    logic [3:0]         pol;
    logic [COLOR_W-1:0] pal_rgb, fmt_out, pdata_q;
    logic [IDX_W-1:0]   pal_idx;
    lcd_state_t         st;
    logic [1:0]         col_l, row_l, rowlo_l, fc;
    logic               row_zero, eof_set;
    logic               de_q, hs_q, vs_q, fl_q, irq_q, underrun_q;

    assign dual_eff = dual && (mode != PM_COLOR4) && (mode != PM_COLOR8);

    lcd_regs #(.CNT_W(CNT_W), .IDX_W(IDX_W), .COLOR_W(COLOR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .pal_idx(pal_idx), .h_act(h_act), .v_act(v_act), .l_wait(l_wait),
        .f_wait(f_wait), .en(en), .mode(mode), .dual(dual), .narrow(narrow),
        .pol(pol), .ctrl_wr(ctrl_wr), .pal_rgb(pal_rgb)
    );

    lcd_timing #(.CNT_W(CNT_W)) u_timing (
        .clk(clk), .rst_n(rst_n), .en(en), .h_act(h_act), .v_act(v_act),
        .l_wait(l_wait), .f_wait(f_wait), .dual(dual_eff), .st(st),
        .col_l(col_l), .row_l(row_l), .rowlo_l(rowlo_l), .row_zero(row_zero),
        .fc(fc), .eof_set(eof_set)
    );

    lcd_pixfmt #(.IDX_W(IDX_W), .COLOR_W(COLOR_W)) u_fmt (
        .mode(mode), .narrow(narrow), .dual(dual_eff), .fc(fc), .col_l(col_l),
        .row_l(row_l), .rowlo_l(rowlo_l), .code_up(pix_data[IDX_W-1:0]),
        .code_lo(pix_data[PIX_W-1:IDX_W]), .pal_rgb(pal_rgb),
        .pal_idx(pal_idx), .pix_out(fmt_out)
    );

    assign pix_ready = (st == ST_ACTIVE);

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_q       <= 1'b0;
            hs_q       <= 1'b0;
            vs_q       <= 1'b0;
            fl_q       <= 1'b0;
            irq_q      <= 1'b0;
            pdata_q    <= '0;
            underrun_q <= 1'b0;
        end else begin
            de_q  <= (st == ST_ACTIVE);
            hs_q  <= (st == ST_LWAIT);
            vs_q  <= (st == ST_FWAIT) && row_zero;
            fl_q  <= ((st == ST_ACTIVE) || (st == ST_LWAIT)) && row_zero;
            irq_q <= eof_set;
            if (st == ST_ACTIVE) begin
                if (pix_valid) pdata_q <= fmt_out;
            end else begin
                pdata_q <= '0;
            end
            if (ctrl_wr)                             underrun_q <= 1'b0;
            else if ((st == ST_ACTIVE) && !pix_valid) underrun_q <= 1'b1;
        end
    end

    assign lcd_hsync = hs_q ^ pol[POL_HS];
    assign lcd_vsync = vs_q ^ pol[POL_VS];
    assign lcd_first = fl_q ^ pol[POL_FL];
    assign lcd_de    = de_q ^ pol[POL_DE];
    assign lcd_data  = pdata_q;
    assign frame_irq = irq_q;
    assign underrun  = underrun_q;
endmodule

// File: rtl/lcd_panel_ctrl_chk.sv
module lcd_panel_ctrl_chk #(
    parameter int COLOR_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pix_ready,
    input logic               pix_valid,
    input logic               de_q,
    input logic               hs_q,
    input logic               vs_q,
    input logic               irq_q,
    input logic               underrun_q,
    input logic               ctrl_wr,
    input logic [COLOR_W-1:0] pdata_q
);
    a_r2_ready_gives_de: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |=> de_q);
    a_r3_hs_excludes_de: assert property (@(posedge clk) disable iff (!rst_n)
        hs_q |-> !de_q);
    a_r4_vs_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
        vs_q |-> (!de_q && !hs_q));
    a_r6_irq_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    a_r12_hold_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ready && !pix_valid && de_q) |=> $stable(pdata_q));
    a_r12_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ready && !pix_valid && !ctrl_wr) |=> underrun_q);
    a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun_q && !ctrl_wr) |=> underrun_q);
endmodule

bind lcd_panel_ctrl lcd_panel_ctrl_chk #(.COLOR_W(COLOR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_ready(pix_ready), .pix_valid(pix_valid),
    .de_q(de_q), .hs_q(hs_q), .vs_q(vs_q), .irq_q(irq_q),
    .underrun_q(underrun_q), .ctrl_wr(ctrl_wr), .pdata_q(pdata_q)
);

// File: tb/test_lcd_panel_ctrl.sv
`timescale 1ns/1ps
module test_lcd_panel_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [11:0] reg_wdata = '0;
    logic        pix_valid = 1'b0;
    logic        pix_ready;
    logic [11:0] pix_data = '0;
    logic        lcd_hsync, lcd_vsync, lcd_first, lcd_de, frame_irq, underrun;
    logic [11:0] lcd_data;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    int c_de, c_hs, c_vs, c_fl, c_irq, c_dot, irq_at, run_de, run_hs, max_de, max_hs;

    always #2.5 clk = ~clk;

    lcd_panel_ctrl i_lcd_panel_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_data(pix_data), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
        .lcd_first(lcd_first), .lcd_de(lcd_de), .lcd_data(lcd_data),
        .frame_irq(frame_irq), .underrun(underrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [11:0] pal_val(input int i);
        return 12'(((i * 11) ^ 12'h5a3) & 12'hfff);
    endfunction

    function automatic logic [7:0] code_at(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    // control word: en bit0, mode 3:1, dual 4, narrow 5, polarity 9:6
    function automatic logic [11:0] ctl(input int en, input int md, input int du,
                                        input int nw, input int pl);
        return 12'(en | (md << 1) | (du << 4) | (nw << 5) | (pl << 6));
    endfunction

    task automatic wr(input int a, input logic [11:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 9'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // R13: register map (0 h_active, 1 v_active, 2 line wait, 3 frame wait, 4 control)
    task automatic cfg(input int h, input int v, input int lw, input int fw, input logic [11:0] c);
        wr(4, c & 12'hffe);
        wr(0, 12'(h)); wr(1, 12'(v)); wr(2, 12'(lw)); wr(3, 12'(fw));
        wr(4, c);
    endtask

    task automatic wait_irq();
        do @(negedge clk); while (!frame_irq);
    endtask

    task automatic measure(input int n);
        c_de = 0; c_hs = 0; c_vs = 0; c_fl = 0; c_irq = 0; c_dot = 0; irq_at = 0;
        run_de = 0; run_hs = 0; max_de = 0; max_hs = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            c_de += int'(lcd_de); c_hs += int'(lcd_hsync);
            c_vs += int'(lcd_vsync); c_fl += int'(lcd_first);
            if (frame_irq) begin c_irq++; irq_at = i; end
            if (lcd_de) c_dot += int'(lcd_data[0]);
            run_de = lcd_de ? run_de + 1 : 0;
            run_hs = lcd_hsync ? run_hs + 1 : 0;
            if (run_de > max_de) max_de = run_de;
            if (run_hs > max_hs) max_hs = run_hs;
        end
    endtask

    // streams colour codes, checks each data-enabled sample against the code taken one edge earlier
    task automatic drive_color(input int n, input bit nw, input int drop_k, input string req);
        logic [7:0]  last = '0;
        logic [11:0] e;
        int k = 0;
        int rdy = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (lcd_de) begin
                e = nw ? pal_val(int'(last[3:0])) : pal_val(int'(last));
                if (nw) e = {3'b000, e[11:9], e[7:5], e[3:1]};
                chk(req, int'(lcd_data), int'(e));
            end
            if (pix_ready) begin
                if (rdy == drop_k) pix_valid = 1'b0;
                else begin
                    pix_valid = 1'b1;
                    last = code_at(k);
                    pix_data = {4'b0, last};
                    k++;
                end
                rdy++;
            end
        end
        pix_valid = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 de", int'(lcd_de), 0);
        chk("R1 hsync", int'(lcd_hsync), 0);
        chk("R1 vsync", int'(lcd_vsync), 0);
        chk("R1 first", int'(lcd_first), 0);
        chk("R1 irq", int'(frame_irq), 0);
        chk("R1 underrun", int'(underrun), 0);
        chk("R1 ready", int'(pix_ready), 0);
        chk("R1 data", int'(lcd_data), 0);
    endtask

    task automatic t_frame_timing();
        pix_valid = 1'b1;
        cfg(4, 4, 2, 2, ctl(1, 4, 0, 0, 0));
        wait_irq();
        measure(36);
        chk("R2 de clocks per frame", c_de, 16);
        chk("R2 de run per line", max_de, 4);
        chk("R3 hsync clocks per frame", c_hs, 8);
        chk("R3 hsync run", max_hs, 2);
        chk("R4 vsync clocks", c_vs, 6);
        chk("R4 first-line clocks", c_fl, 6);
        chk("R4 frame period", irq_at, 36);
        chk("R6 irq pulses per frame", c_irq, 1);
    endtask

    task automatic t_polarity();
        cfg(4, 4, 2, 2, ctl(1, 4, 0, 0, 15));
        wait_irq();
        measure(36);
        chk("R5 inverted de", c_de, 20);
        chk("R5 inverted hsync", c_hs, 28);
        chk("R5 inverted vsync", c_vs, 30);
        chk("R5 inverted first", c_fl, 30);
    endtask

    task automatic t_color8();
        for (int i = 0; i < 256; i++) wr(256 + i, pal_val(i));
        cfg(4, 4, 2, 2, ctl(1, 4, 0, 0, 0));
        wait_irq();
        drive_color(36, 1'b0, -1, "R7 R13 colour8 lookup");
    endtask

    task automatic t_color4_narrow();
        cfg(4, 4, 2, 2, ctl(1, 3, 0, 1, 0));
        wait_irq();
        drive_color(36, 1'b1, -1, "R8 R9 colour4 narrow");
    endtask

    task automatic t_gray_frc();
        pix_valid = 1'b1;
        pix_data = 12'd2;
        cfg(4, 4, 2, 2, ctl(1, 1, 0, 0, 0));
        wait_irq(); measure(36);
        chk("R10 gray2 level2 one frame", c_dot, 8);
        wait_irq(); measure(144);
        chk("R10 gray2 level2 four frames", c_dot, 32);
        pix_data = 12'd1;
        wait_irq(); measure(144);
        chk("R10 gray2 level1", c_dot, 16);
        pix_data = 12'd3;
        wait_irq(); measure(144);
        chk("R10 gray2 level3", c_dot, 64);
        pix_data = 12'd6;
        cfg(4, 4, 2, 2, ctl(1, 2, 0, 0, 0));
        wait_irq(); measure(144);
        chk("R10 gray4 level6", c_dot, 32);
        pix_data = 12'd0;
        cfg(4, 4, 2, 2, ctl(1, 0, 0, 0, 0));
        wait_irq(); measure(144);
        chk("R10 gray1 off", c_dot, 0);
    endtask

    task automatic t_dual();
        bit lu = 0, ll = 0;
        int k = 0;
        pix_valid = 1'b1;
        cfg(4, 4, 2, 2, ctl(1, 0, 1, 0, 0));
        wait_irq();
        measure(24);
        chk("R11 dual de per frame", c_de, 8);
        chk("R11 dual frame period", irq_at, 24);
        wait_irq();
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (lcd_de) begin
                chk("R11 upper dot", int'(lcd_data[0]), int'(lu));
                chk("R11 lower dot", int'(lcd_data[4]), int'(ll));
            end
            if (pix_ready) begin
                lu = k[0]; ll = k[1];
                pix_data = {3'b0, ll, 7'b0, lu};
                k++;
            end
        end
    endtask

    task automatic t_underrun();
        pix_valid = 1'b1;
        cfg(4, 4, 2, 2, ctl(1, 4, 0, 0, 0));
        wait_irq();
        chk("R12 flag clear at start", int'(underrun), 0);
        drive_color(36, 1'b0, 5, "R12 hold on missing pixel");
        chk("R12 flag set and sticky", int'(underrun), 1);
        wr(4, ctl(1, 4, 0, 0, 0));
        chk("R12 flag cleared by control write", int'(underrun), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame_timing();
        t_polarity();
        t_color8();
        t_color4_narrow();
        t_gray_frc();
        t_dual();
        t_underrun();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule